// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This block makes the three per-descriptor decisions a descriptor-driven DMA channel sequencer needs while a command is executing:
- whether the channel must stall (wait),
- whether control moves to the descriptor's branch target,
- whether an interrupt is requested.

Each decision reads a 2-bit mode taken from the command word. It also reads a 32-bit select register belonging to that decision. The select register holds a 4-bit mask and a 4-bit compare value. The test passes when the masked device-status bits equal the masked compare value. The mode then chooses never, always, act when the test passes, or act when it fails.

The wait and branch results are combinational and follow the inputs at once. When no branch is taken, the block flags that the sequencer should advance to the next sequential descriptor. The interrupt decision is sampled on an evaluate strobe and comes out as a registered one-cycle pulse.

Top module: `dma_cond_eval`

## Requirements
- R1: A decision's condition is true exactly when (dev_stat_i[3:0] AND mask) equals (value AND mask). The mask is bits 19:16 and the value is bits 3:0 of that decision's select register. Status bits 7:4 have no effect on any output.
- R2: Mode 2'b00 (never) holds the decision's result low for every status and select setting.
- R3: Mode 2'b11 (always) holds the decision's result high for every status and select setting.
- R4: Mode 2'b01 makes the decision's result equal to its condition.
- R5: Mode 2'b10 makes the decision's result equal to the inverse of its condition.
- R6: The decisions are independent of each other:
  - wait uses cmd_i[1:0] with wait_sel_i;
  - branch uses cmd_i[3:2] with br_sel_i;
  - interrupt uses cmd_i[5:4] with irq_sel_i.
- R7: irq_o is high for exactly the one cycle after a rising clock edge where eval_i was high and the interrupt decision was true. It is low in every other cycle.
- R8: advance_o is always the inverse of branch_o.
- R9: While rst_ni is low, irq_o is low.
- R10: Select register bits outside 19:16 and 3:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe for the interrupt decision |
| cmd_i | input | 6 | Mode fields of the command word |
| dev_stat_i | input | 8 | Channel device-status bits |
| irq_sel_i | input | 32 | Interrupt select register |
| br_sel_i | input | 32 | Branch select register |
| wait_sel_i | input | 32 | Wait select register |
| wait_o | output | 1 | Channel must wait |
| branch_o | output | 1 | Branch taken |
| advance_o | output | 1 | Advance to next sequential descriptor |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
Wait, branch and advance are combinational. A wrong mask slice, a swapped mode field or an inverted mode decode therefore shows up on those outputs in the same cycle the inputs are applied. A bad interrupt path shows up one edge later: the pulse is missing, stretched past one cycle, or present without a strobe. Random vectors mix the modes with partial masks, so a fault confined to one bit of mask or status is still exposed.

// File: rtl/dma_cond_pkg.sv
package dma_cond_pkg;
  typedef enum logic [1:0] {
    MODE_NEVER    = 2'b00,
    MODE_IF_TRUE  = 2'b01,
    MODE_IF_FALSE = 2'b10,
    MODE_ALWAYS   = 2'b11
  } cond_mode_e;

  localparam int unsigned DEC_WAIT   = 0;
  localparam int unsigned DEC_BRANCH = 1;
  localparam int unsigned DEC_IRQ    = 2;
  localparam int unsigned NUM_DEC    = 3;
  localparam int unsigned MODE_W     = 2;
endpackage

// File: rtl/dma_cond_match.sv
module dma_cond_match #(
  parameter int unsigned SEL_W    = 32,
  parameter int unsigned CMP_W    = 4,
  parameter int unsigned MASK_LSB = 16
) (
  input  logic [CMP_W-1:0] stat_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             match_o
);
  localparam int unsigned MASK_MSB = MASK_LSB + CMP_W - 1;

  logic [CMP_W-1:0] mask;
  logic [CMP_W-1:0] value;

  assign mask    = sel_i[MASK_MSB:MASK_LSB];
  assign value   = sel_i[CMP_W-1:0];
  assign match_o = ((stat_i & mask) == (value & mask));
endmodule

// File: rtl/dma_cond_mode.sv
module dma_cond_mode
  import dma_cond_pkg::*;
(
  input  cond_mode_e mode_i,
  input  logic       cond_i,
  output logic       act_o
);
  always_comb begin
    unique case (mode_i)
      MODE_NEVER:    act_o = 1'b0;
      MODE_IF_TRUE:  act_o = cond_i;
      MODE_IF_FALSE: act_o = ~cond_i;
      MODE_ALWAYS:   act_o = 1'b1;
      default:       act_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_cond_eval.sv
module dma_cond_eval
  import dma_cond_pkg::*;
#(
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned SEL_W    = 32,
  parameter int unsigned CMP_W    = 4,
  parameter int unsigned MASK_LSB = 16,
  localparam int unsigned CMD_W   = NUM_DEC * MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [STAT_W-1:0] dev_stat_i,
  input  logic [SEL_W-1:0]  irq_sel_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  output logic              wait_o,
  output logic              branch_o,
  output logic              advance_o,
  output logic              irq_o
);
  logic [NUM_DEC-1:0][SEL_W-1:0] sel;
  logic [NUM_DEC-1:0]            cond;
  logic [NUM_DEC-1:0]            act;
  logic                          irq_q;
  logic                          stat_unused;

  assign sel[DEC_WAIT]   = wait_sel_i;
  assign sel[DEC_BRANCH] = br_sel_i;
  assign sel[DEC_IRQ]    = irq_sel_i;

  // Upper status bits take no part in the compare.
  assign stat_unused = ^dev_stat_i[STAT_W-1:CMP_W];

  // One condition matcher and one mode decoder per decision.
  // The mode field for decision d sits at cmd_i[2d+1:2d].
  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
    logic sel_unused;

    assign sel_unused = ^{sel[d][SEL_W-1:MASK_LSB+CMP_W], sel[d][MASK_LSB-1:CMP_W]};

    dma_cond_match #(
      .SEL_W    (SEL_W),
      .CMP_W    (CMP_W),
      .MASK_LSB (MASK_LSB)
    ) i_match (
      .stat_i  (dev_stat_i[CMP_W-1:0]),
      .sel_i   (sel[d]),
      .match_o (cond[d])
    );

    dma_cond_mode i_mode (
      .mode_i (cond_mode_e'(cmd_i[MODE_W*d +: MODE_W])),
      .cond_i (cond[d]),
      .act_o  (act[d])
    );
  end

  assign wait_o    = act[DEC_WAIT];
  assign branch_o  = act[DEC_BRANCH];
  assign advance_o = ~act[DEC_BRANCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= eval_i & act[DEC_IRQ];
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_cond_eval_chk.sv
module dma_cond_eval_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        eval_i,
  input logic [5:0]  cmd_i,
  input logic [7:0]  dev_stat_i,
  input logic [31:0] wait_sel_i,
  input logic        wait_o,
  input logic        branch_o,
  input logic        advance_o,
  input logic        irq_o
);
  logic wait_cond;

  assign wait_cond = ((dev_stat_i[3:0] & wait_sel_i[19:16]) == (wait_sel_i[3:0] & wait_sel_i[19:16]));

  // R2
  wait_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[1:0] == 2'b00) |-> !wait_o);

  // R3
  branch_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[3:2] == 2'b11) |-> branch_o);

  // R4
  wait_if_true_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[1:0] == 2'b01) |-> (wait_o == wait_cond));

  // R5
  wait_if_false_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[1:0] == 2'b10) |-> (wait_o == !wait_cond));

  // R7
  irq_needs_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(eval_i));

  // R7
  irq_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && cmd_i[5:4] == 2'b00) |=> !irq_o);

  // R8
  advance_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_o != branch_o);
endmodule

bind dma_cond_eval dma_cond_eval_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eval_i     (eval_i),
  .cmd_i      (cmd_i),
  .dev_stat_i (dev_stat_i),
  .wait_sel_i (wait_sel_i),
  .wait_o     (wait_o),
  .branch_o   (branch_o),
  .advance_o  (advance_o),
  .irq_o      (irq_o)
);

// File: tb/test_dma_cond_eval.sv
module test_dma_cond_eval;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eval_i = 1'b0;
  logic [5:0]  cmd_i = '0;
  logic [7:0]  dev_stat_i = '0;
  logic [31:0] irq_sel_i = '0;
  logic [31:0] br_sel_i = '0;
  logic [31:0] wait_sel_i = '0;
  logic        wait_o, branch_o, advance_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic wt;
    logic br;
    logic irq;
  } exp_t;

  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  dma_cond_eval i_dma_cond_eval (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eval_i     (eval_i),
    .cmd_i      (cmd_i),
    .dev_stat_i (dev_stat_i),
    .irq_sel_i  (irq_sel_i),
    .br_sel_i   (br_sel_i),
    .wait_sel_i (wait_sel_i),
    .wait_o     (wait_o),
    .branch_o   (branch_o),
    .advance_o  (advance_o),
    .irq_o      (irq_o)
  );

  // R1, R10: model of the masked compare
  function automatic logic cond_f(logic [7:0] st, logic [31:0] s);
    return ((st[3:0] & s[19:16]) == (s[3:0] & s[19:16]));
  endfunction

  // R2..R5: model of the mode decode
  function automatic logic act_f(logic [1:0] m, logic c);
    case (m)
      2'b00:   return 1'b0;
      2'b01:   return c;
      2'b10:   return !c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Driver: apply a vector at negedge, push the expected results, hold until the next negedge
  task automatic drive(logic ev, logic [5:0] c, logic [7:0] st,
                       logic [31:0] si, logic [31:0] sb, logic [31:0] sw);
    exp_t e;
    @(negedge clk_i);
    eval_i = ev; cmd_i = c; dev_stat_i = st;
    irq_sel_i = si; br_sel_i = sb; wait_sel_i = sw;
    e.wt  = act_f(c[1:0], cond_f(st, sw));
    e.br  = act_f(c[3:2], cond_f(st, sb));
    e.irq = ev & act_f(c[5:4], cond_f(st, si));
    exp_q.push_back(e);
    @(posedge clk_i);
  endtask

  // Monitor: sample 2 ns after each edge, with inputs still held
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R6 wait",      wait_o,    e.wt);
        chk("R6 branch",    branch_o,  e.br);
        chk("R8 advance",   advance_o, !e.br);
        chk("R7 irq pulse", irq_o,     e.irq);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
  end

  initial begin
    #35;
    chk("R9 irq in reset", irq_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 / R3: never and always ignore the condition
    drive(1, 6'b00_00_00, 8'h0F, 32'h000F_0000, 32'h000F_0000, 32'h000F_0000);
    drive(1, 6'b11_11_11, 8'h0F, 32'h000F_0000, 32'h000F_0000, 32'h000F_0000);

    // R4 / R5: if-true and if-false, condition met (full mask, equal value)
    drive(1, 6'b01_01_01, 8'h05, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005);
    drive(1, 6'b10_10_10, 8'h05, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005);

    // R4 / R5: condition not met
    drive(1, 6'b01_01_01, 8'h04, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005);
    drive(1, 6'b10_10_10, 8'h04, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005);

    // R1: a partial mask hides the differing bit; status bits 7:4 are ignored
    drive(1, 6'b01_01_01, 8'hF4, 32'h000E_0005, 32'h000E_0005, 32'h000E_0005);

    // R10: junk outside the mask and value fields
    drive(1, 6'b01_01_01, 8'h03, 32'hFFF0_FFF3, 32'hABC0_1233, 32'h5550_AAA3);

    // R6: each decision uses its own register
    drive(1, 6'b01_01_01, 8'h01, 32'h000F_0001, 32'h000F_0002, 32'h000F_0001);

    // R7: no pulse without the strobe; the pulse lasts one cycle
    drive(0, 6'b11_00_00, 8'h00, 32'h0, 32'h0, 32'h0);
    drive(1, 6'b11_00_00, 8'h00, 32'h0, 32'h0, 32'h0);
    drive(0, 6'b11_00_00, 8'h00, 32'h0, 32'h0, 32'h0);

    for (int i = 0; i < 400; i++)
      drive(1'($urandom), 6'($urandom), 8'($urandom), $urandom, $urandom, $urandom);

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule